// File: doc/BRIEF.md
# Bipolar Line Code Decoder (AMI / HDB3 / B8ZS)

This block sits in the receive path of an E1 or T1 line interface. It takes the recovered bipolar symbol stream as two rail bits, one for a positive mark and one for a negative mark, together with a bit-time enable. It turns that stream back into unipolar NRZ data. In the zero-suppression modes it recognises the code words that the far-end transmitter put in place of long zero runs, spotting them by their bipolar violations. It then restores the zeros those code words stand for, and removes both the violation pulses and the balancing pulses.

Every symbol passes through a short window register. A complete substitution word is therefore inside the window before its first bit reaches the output. The delay is fixed for each mode: 4 bit times for AMI and HDB3, and 8 bit times for B8ZS. In dual-rail output mode the raw rail bits come out with the same delay, so a change of output format does not shift the data. A violation that belongs to no valid code word leaves the block as a data 1, and a one-clock code-violation strobe marks it.

Top module: `lcd_bipolar_decoder`

## Requirements
- R1: With `code_sel` = 2'b00 (AMI), a mark on either rail decodes to 1 and a space decodes to 0. The symbol accepted on enable k appears on `dout_pos` after enable k+4.
- R2: A mark is a violation when it has the same polarity as the previous mark. The first mark after reset is never a violation.
- R3: With `code_sel` = 2'b01 (HDB3), the sequence space, space, space, violation decodes to four zeros.
- R4: In HDB3 mode, a non-violating mark followed by two spaces and then a same-polarity violation decodes to four zeros.
- R5: With `code_sel` = 2'b10 (B8ZS), the eight-symbol word 0,0,0,V,B,0,V,B decodes to eight zeros, where each B alternates from the mark before it. Latency in this mode is 8 enables.
- R6: A violation that is not part of a valid word for the mode decodes to 1. In single-rail mode `code_viol` is high for exactly the one clock after the enable that outputs it.
- R7: With `dual_out` = 1, `dout_pos`/`dout_neg` carry the raw positive/negative rails, with no substitution removed, and with the same per-mode latency as single-rail data. With `dual_out` = 0, `dout_neg` is 0.
- R8: Outputs change only on clocks where `bit_en` is high. While `bit_en` is low they hold, and `code_viol` is 0.
- R9: After reset, `dout_pos`, `dout_neg` and `code_viol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_en | input | 1 | One symbol is accepted on each clock where this is high |
| rx_pos | input | 1 | Positive mark present in this symbol |
| rx_neg | input | 1 | Negative mark present in this symbol |
| code_sel | input | 2 | 00 AMI, 01 HDB3, 10 B8ZS, 11 treated as AMI |
| dual_out | input | 1 | 1: raw dual-rail output, 0: decoded single-rail output |
| dout_pos | output | 1 | Decoded data (single rail) or delayed positive rail |
| dout_neg | output | 1 | Delayed negative rail (dual rail), else 0 |
| code_viol | output | 1 | One-clock strobe for an unmatched violation |

## Verification
The assertions assume that `rx_pos` and `rx_neg` are never high together, that `code_sel` and `dual_out` stay constant between resets, and that a B8ZS stream begins with a mark, so that the first substitution has a reference polarity. The stimulus comes from a bench-side line encoder that always starts from reset with a fresh polarity state. It applies mode changes only under reset, and the hand-built violation cases are assembled from legal single-rail marks. Enable gaps are placed between symbols, never inside a clock, so the window register advances only on real bit times.

// File: rtl/lcd_pkg.sv
package lcd_pkg;

  localparam int LC_HDB3_LEN = 4;
  localparam int LC_B8ZS_LEN = 8;

  typedef enum logic [1:0] {
    LC_AMI  = 2'b00,
    LC_HDB3 = 2'b01,
    LC_B8ZS = 2'b10,
    LC_RSVD = 2'b11
  } lc_mode_e;

  // one bit time in the window: raw rails, decoded mark, violation tag
  typedef struct packed {
    logic rp;
    logic rn;
    logic dat;
    logic viol;
  } lc_slot_t;

endpackage

// File: rtl/lcd_polarity.sv
module lcd_polarity
  import lcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  logic     pos_i,
  input  logic     neg_i,
  output lc_slot_t slot_o
);

  logic last_q, last_d;
  logic seen_q, seen_d;
  logic mark;

  assign mark = pos_i | neg_i;

  always_comb begin
    slot_o.rp   = pos_i;
    slot_o.rn   = neg_i;
    slot_o.dat  = mark;
    slot_o.viol = mark & seen_q & (pos_i == last_q);
  end

  always_comb begin
    last_d = last_q;
    seen_d = seen_q;
    if (en_i && mark) begin
      last_d = pos_i;
      seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      last_q <= last_d;
      seen_q <= seen_d;
    end
  end

  // R2: the remembered polarity is that of the latest accepted mark
  a_r2_pol_memory: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && (pos_i ^ neg_i)) |=> (last_q == $past(pos_i)));

endmodule

// File: rtl/lcd_window.sv
module lcd_window
  import lcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  lc_mode_e mode_i,
  input  lc_slot_t slot_i,
  output lc_slot_t exit_o
);

  localparam int DEPTH = LC_B8ZS_LEN;

  lc_slot_t [DEPTH-1:0] win_q, win_d, shf;
  logic [DEPTH-1:0] dat_vec;
  logic hit_h, hit_b, clr_h, clr_b;

  assign shf[0] = slot_i;
  generate
    for (genvar i = 1; i < DEPTH; i++) begin : g_shf
      assign shf[i] = win_q[i-1];
    end
    for (genvar i = 0; i < DEPTH; i++) begin : g_dat
      assign dat_vec[i] = win_q[i].dat;
    end
  endgenerate

  // 000V or B00V: newest is V, two spaces before it, oldest is a space or a legal mark
  assign hit_h = shf[0].viol & ~shf[1].dat & ~shf[2].dat & ~shf[3].viol;

  // 000VB0VB, newest symbol in slot 0
  assign hit_b = shf[0].dat & ~shf[0].viol & shf[1].viol & ~shf[2].dat
               & shf[3].dat & ~shf[3].viol & shf[4].viol
               & ~shf[5].dat & ~shf[6].dat & ~shf[7].dat;

  assign clr_h = en_i & (mode_i == LC_HDB3) & hit_h;
  assign clr_b = en_i & (mode_i == LC_B8ZS) & hit_b;

  always_comb begin
    win_d = win_q;
    if (en_i) begin
      for (int i = 0; i < DEPTH; i++) begin
        win_d[i] = shf[i];
        if ((clr_h && i < LC_HDB3_LEN) || (clr_b && i < LC_B8ZS_LEN)) begin
          win_d[i].dat  = 1'b0;
          win_d[i].viol = 1'b0;
        end
      end
    end
  end

  assign exit_o = (mode_i == LC_B8ZS) ? win_q[LC_B8ZS_LEN-1] : win_q[LC_HDB3_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
    end else begin
      win_q <= win_d;
    end
  end

  // R3 R4: a recognised HDB3 word leaves no marks in its four slots
  a_r3_hdb3_restore: assert property (@(posedge clk) disable iff (!rst_n)
    clr_h |=> (dat_vec[LC_HDB3_LEN-1:0] == '0));

  // R5: a recognised B8ZS word leaves no marks in its eight slots
  a_r5_b8zs_restore: assert property (@(posedge clk) disable iff (!rst_n)
    clr_b |=> (dat_vec[LC_B8ZS_LEN-1:0] == '0));

endmodule

// File: rtl/lcd_outfmt.sv
module lcd_outfmt
  import lcd_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en_i,
  input  logic     dual_i,
  input  lc_slot_t exit_i,
  output logic     pos_o,
  output logic     neg_o,
  output logic     cv_o
);

  logic pos_d, neg_d, cv_d;

  always_comb begin
    pos_d = pos_o;
    neg_d = neg_o;
    cv_d  = 1'b0;
    if (en_i) begin
      pos_d = dual_i ? exit_i.rp : exit_i.dat;
      neg_d = dual_i ? exit_i.rn : 1'b0;
      cv_d  = exit_i.viol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_o <= 1'b0;
      neg_o <= 1'b0;
      cv_o  <= 1'b0;
    end else begin
      pos_o <= pos_d;
      neg_o <= neg_d;
      cv_o  <= cv_d;
    end
  end

  // R8: no enable, no output movement
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(pos_o) && $stable(neg_o) && !cv_o));

  // R6: strobe only follows an enable
  a_r6_cv_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cv_o |-> $past(en_i));

  // R6: unmatched violation comes out as a 1 with the strobe
  a_r6_cv_is_one: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !dual_i && exit_i.viol) |=> (cv_o && pos_o));

  // R7: single rail keeps the negative output quiet
  a_r7_single_neg: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !dual_i) |=> !neg_o);

endmodule

// File: rtl/lcd_bipolar_decoder.sv
module lcd_bipolar_decoder
  import lcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic       rx_pos,
  input  logic       rx_neg,
  input  logic [1:0] code_sel,
  input  logic       dual_out,
  output logic       dout_pos,
  output logic       dout_neg,
  output logic       code_viol
);

  logic     rst_meta_q, rst_sync_q;
  lc_slot_t in_slot, exit_slot;
  lc_mode_e mode;

  assign mode = lc_mode_e'(code_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  lcd_polarity u_pol (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .en_i   (bit_en),
    .pos_i  (rx_pos),
    .neg_i  (rx_neg),
    .slot_o (in_slot)
  );

  lcd_window u_win (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .en_i   (bit_en),
    .mode_i (mode),
    .slot_i (in_slot),
    .exit_o (exit_slot)
  );

  lcd_outfmt u_out (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .en_i   (bit_en),
    .dual_i (dual_out),
    .exit_i (exit_slot),
    .pos_o  (dout_pos),
    .neg_o  (dout_neg),
    .cv_o   (code_viol)
  );

endmodule

// File: tb/sim_lcd_bipolar_decoder.sv
`timescale 1ns/1ps
module sim_lcd_bipolar_decoder;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_en;
  logic       rx_pos, rx_neg;
  logic [1:0] code_sel;
  logic       dual_out;
  logic       dout_pos, dout_neg, code_viol;

  always #5 clk = ~clk;

  lcd_bipolar_decoder u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_pos(rx_pos), .rx_neg(rx_neg),
    .code_sel(code_sel), .dual_out(dual_out),
    .dout_pos(dout_pos), .dout_neg(dout_neg), .code_viol(code_viol)
  );

  // scoreboard item: {data, pos rail, neg rail, strobe}
  logic [3:0] expq[$];
  int    checks = 0, errors = 0;
  int    n_en = 0, lat = 4, sent = 0, gap_every = 0;
  logic  en_d = 1'b0;
  logic  bdual = 1'b0;
  logic  tx_last;
  int    tx_cnt;
  string cur_req = "R1";
  logic  finished = 1'b0;

  always @(posedge clk) en_d <= bit_en;

  // monitor
  always @(negedge clk) begin
    if (rst_n && en_d) begin
      n_en++;
      if (n_en > lat && expq.size() > 0) begin
        logic [3:0] it;
        logic ep, en, ec;
        it = expq.pop_front();
        ep = bdual ? it[2] : it[3];
        en = bdual ? it[1] : 1'b0;
        ec = bdual ? code_viol : it[0];
        checks++;
        if (dout_pos !== ep || dout_neg !== en || code_viol !== ec) begin
          errors++;
          $display("FAIL %s item %0d: pos=%b/%b neg=%b/%b cv=%b/%b (actual/expected)",
                   cur_req, n_en - lat, dout_pos, ep, dout_neg, en, code_viol, ec);
        end
      end
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic d, input int l);
    rst_n = 1'b0; bit_en = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
    code_sel = m; dual_out = d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expq.delete();
    n_en = 0; lat = l; bdual = d; sent = 0;
    tx_last = 1'b0; tx_cnt = 0;
  endtask

  task automatic send(input logic p, input logic n, input logic d, input logic cv);
    bit_en = 1'b1; rx_pos = p; rx_neg = n;
    expq.push_back({d, p, n, cv});
    @(negedge clk);
    bit_en = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
    sent++;
    if (gap_every != 0 && (sent % gap_every) == 0) repeat (2) @(negedge clk);
  endtask

  task automatic mark_pol(input logic pol);
    send(pol, !pol, 1'b0, 1'b0);
  endtask

  task automatic ami_one();
    tx_last = !tx_last;
    send(tx_last, !tx_last, 1'b1, 1'b0);
    tx_cnt++;
  endtask

  task automatic zero();
    send(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic run_ami(input logic [63:0] data);
    for (int i = 63; i >= 0; i--) begin
      if (data[i]) ami_one(); else zero();
    end
  endtask

  task automatic run_hdb3(input logic [63:0] data);
    int i;
    i = 63;
    while (i >= 0) begin
      if (i >= 3 && data[i -: 4] == 4'b0000) begin
        if (tx_cnt % 2 == 1) begin
          zero(); zero(); zero();
          mark_pol(tx_last);            // 000V
        end else begin
          tx_last = !tx_last;
          mark_pol(tx_last);            // B
          zero(); zero();
          mark_pol(tx_last);            // V
        end
        tx_cnt = 0;
        i -= 4;
      end else begin
        if (data[i]) ami_one(); else zero();
        i--;
      end
    end
  endtask

  task automatic run_b8zs(input logic [63:0] data);
    int i;
    logic l;
    i = 63;
    while (i >= 0) begin
      if (i >= 7 && data[i -: 8] == 8'h00) begin
        l = tx_last;
        zero(); zero(); zero();
        mark_pol(l); mark_pol(!l); zero(); mark_pol(!l); mark_pol(l);
        i -= 8;
      end else begin
        if (data[i]) ami_one(); else zero();
        i--;
      end
    end
  endtask

  task automatic drain(input int k);
    for (int j = 0; j < k; j++) zero();
  endtask

  task automatic idle_hold_check();
    logic hp, hn;
    bit_en = 1'b0;
    @(negedge clk);
    hp = dout_pos; hn = dout_neg;
    repeat (4) @(negedge clk);
    chk("R8 hold pos", dout_pos, hp);
    chk("R8 hold neg", dout_neg, hn);
    chk("R8 no strobe", code_viol, 1'b0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    // R9: reset state
    do_reset(2'b00, 1'b0, 4);
    chk("R9 pos", dout_pos, 1'b0);
    chk("R9 neg", dout_neg, 1'b0);
    chk("R9 cv", code_viol, 1'b0);

    // R1: AMI data, latency 4, with enable gaps
    cur_req = "R1"; gap_every = 5;
    run_ami(64'hA5C3_0F00_1234_8001);
    drain(4);
    idle_hold_check();
    gap_every = 0;

    // R2 R6: first mark clean, repeated polarity is a violation in AMI
    do_reset(2'b00, 1'b0, 4);
    cur_req = "R2 R6 ami";
    send(1, 0, 1, 0); send(1, 0, 1, 1); send(0, 1, 1, 0); zero(); send(0, 1, 1, 1);
    drain(4);

    // R3 R4: HDB3 both substitution forms, with gaps
    do_reset(2'b01, 1'b0, 4);
    cur_req = "R3 R4 hdb3"; gap_every = 7;
    run_hdb3(64'hB080_6100_E008_0003);
    run_hdb3(64'h8000_0000_C000_0001);
    drain(4);
    gap_every = 0;

    // R6: stray violation in HDB3 mode
    do_reset(2'b01, 1'b0, 4);
    cur_req = "R6 hdb3";
    send(0, 1, 1, 0); send(0, 1, 1, 1); zero(); send(1, 0, 1, 0);
    drain(4);

    // R5: B8ZS words, latency 8
    do_reset(2'b10, 1'b0, 8);
    cur_req = "R5 b8zs";
    run_b8zs(64'h8000_C000_0001_2000);
    run_b8zs(64'h9000_0000_0000_0081);
    drain(8);

    // R6: incomplete B8ZS word leaves its violation as a 1
    do_reset(2'b10, 1'b0, 8);
    cur_req = "R6 b8zs";
    send(1, 0, 1, 0); zero(); zero(); zero(); send(1, 0, 1, 1); zero(); zero(); zero();
    drain(8);

    // R7: dual rail, raw rails, same latency as single rail
    do_reset(2'b01, 1'b1, 4);
    cur_req = "R7 dual hdb3";
    run_hdb3(64'hB080_6100_E008_0003);
    drain(4);
    do_reset(2'b10, 1'b1, 8);
    cur_req = "R7 dual b8zs";
    run_b8zs(64'h8000_C000_0001_2000);
    drain(8);

    repeat (3) @(negedge clk);
    summary();
  end

endmodule